// File: doc/BRIEF.md
# Inclusive-OR Decode and Execute Unit

This unit takes one instruction's opcode byte, its ModRM byte, its immediate field and the current operand-size attribute. It decides whether the encoding is one of the inclusive-OR forms. When it is, the unit picks the operand width and the two operands, and sign-extends an 8-bit immediate where the form needs it. It then computes the OR result and the status flags, and reports where the result must be written. The unit is purely combinational. Register and r/m operand values come in on input ports, and no memory is accessed.

An execute stage places this unit beside its register file. The stage presents the accumulator value, the value of the register named by the ModRM reg field, and the r/m value, which has already been fetched when r/m is memory. It then writes `result` back to the place that `destSel` names. For forms narrower than 32 bits, the bits above the active width are copied from the destination operand, so the full 32-bit word can be written back as a partial-register update. Encodings that are not OR raise `notHandled`, and the stage then routes the instruction to some other unit.

Top module: `orx_unit`

## Requirements
- R1: The handled opcodes are 0x08, 0x09, 0x0A, 0x0B, 0x0C, 0x0D, 0x80, 0x81 and 0x83. Any other opcode sets `notHandled`=1. With `notHandled`=1 the outputs are `destSel`=0, `result`=0, every flag 0 and `memOperand`=0.
- R2: Opcodes 0x80, 0x81 and 0x83 are handled only when ModRM bits [5:3] equal 1. Any other value in that field is treated as in R1.
- R3: Opcodes 0x08, 0x0A, 0x0C and 0x80 operate on 8 bits. The other handled opcodes operate on 32 bits when `opSize32`=1 and on 16 bits when `opSize32`=0.
- R4: `destSel` is encoded as 1 = accumulator, 2 = ModRM register, 3 = r/m. Opcodes 0x0C and 0x0D use the accumulator as destination and the immediate as source. Opcodes 0x08 and 0x09 use r/m as destination and the register as source. Opcodes 0x0A and 0x0B use the register as destination and r/m as source. Opcodes 0x80, 0x81 and 0x83 use r/m as destination and the immediate as source.
- R5: Opcodes 0x0C, 0x80 and 0x83 take `immIn[7:0]`. For 0x83 that byte is sign-extended to the active width. Opcodes 0x0D and 0x81 take `immIn` at the full active width.
- R6: Within the active width, each result bit is 0 only when both operand bits are 0.
- R7: Result bits above the active width equal the corresponding bits of the destination operand.
- R8: A handled form always gives `flagCf`=0, `flagOf`=0 and `flagAf`=0.
- R9: `flagSf` is the result's top bit at the active width (bit 7, 15 or 31). `flagZf` is 1 exactly when the result is zero within the active width.
- R10: `flagPf` is 1 when `result[7:0]` holds an even number of 1 bits, whatever the width.
- R11: `memOperand` is 1 for a handled ModRM form whose ModRM bits [7:6] are not 3. It is 0 for 0x0C and 0x0D and whenever ModRM bits [7:6] equal 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 8 | Primary opcode byte |
| modrm | input | 8 | ModRM byte |
| immIn | input | 32 | Immediate field, right-aligned |
| opSize32 | input | 1 | 1 = 32-bit operand size, 0 = 16-bit |
| accIn | input | 32 | Accumulator value |
| regIn | input | 32 | Value of the register named by ModRM bits [5:3] |
| rmIn | input | 32 | r/m operand value |
| result | output | 32 | Full word to write back |
| destSel | output | 2 | Destination: 0 none, 1 accumulator, 2 register, 3 r/m |
| flagCf | output | 1 | Carry flag |
| flagPf | output | 1 | Parity flag |
| flagAf | output | 1 | Auxiliary-carry flag, held at 0 |
| flagZf | output | 1 | Zero flag |
| flagSf | output | 1 | Sign flag |
| flagOf | output | 1 | Overflow flag |
| memOperand | output | 1 | r/m refers to memory |
| notHandled | output | 1 | Encoding is not an OR form |

## Verification
The bench builds the unit with the default `DATA_W` of 32. With that value all three operand widths are reachable: byte, 16-bit and 32-bit. That in turn covers sign extension into both wider widths and upper-bit passthrough above bit 7 and above bit 15. Directed vectors cover every opcode. They also cover group opcodes with wrong reg fields, 0x83 with the immediate's top bit both set and clear, zero and sign results at each width, and both ModRM mod classes. Random vectors drawn from a mix of valid and invalid opcodes fill in the rest.

// File: rtl/orx_pkg.sv
package orx_pkg;
  typedef enum logic [1:0] {
    DEST_NONE = 2'd0,
    DEST_ACC  = 2'd1,
    DEST_REG  = 2'd2,
    DEST_RM   = 2'd3
  } dest_e;

  typedef enum logic [1:0] {
    SRC_IMM = 2'd0,
    SRC_REG = 2'd1,
    SRC_RM  = 2'd2
  } src_e;

  typedef enum logic [1:0] {
    W_BYTE  = 2'd0,
    W_WORD  = 2'd1,
    W_DWORD = 2'd2
  } width_e;

  // Strobes from decode to datapath
  typedef struct packed {
    logic   handled;
    dest_e  dest;
    src_e   src;
    width_e width;
    logic   immByte;
    logic   immSext;
  } ctrl_t;
endpackage

// File: rtl/orx_decode.sv
module orx_decode
  import orx_pkg::*;
(
  input  logic [7:0] opcode,
  input  logic [7:0] modrm,
  input  logic       opSize32,
  output ctrl_t      ctrl,
  output logic       memOperand
);
  localparam logic [2:0] GROUP_OR_EXT = 3'd1;
  localparam logic [1:0] MOD_REGISTER = 2'd3;

  logic   groupOk;
  logic   usesModrm;
  width_e fullWidth;

  assign groupOk   = (modrm[5:3] == GROUP_OR_EXT);
  assign fullWidth = opSize32 ? W_DWORD : W_WORD;

  always_comb begin
    ctrl      = '0;
    usesModrm = 1'b0;
    case (opcode)
      8'h08, 8'h09: begin
        ctrl.handled = 1'b1;
        ctrl.dest    = DEST_RM;
        ctrl.src     = SRC_REG;
        ctrl.width   = opcode[0] ? fullWidth : W_BYTE;
        usesModrm    = 1'b1;
      end
      8'h0A, 8'h0B: begin
        ctrl.handled = 1'b1;
        ctrl.dest    = DEST_REG;
        ctrl.src     = SRC_RM;
        ctrl.width   = opcode[0] ? fullWidth : W_BYTE;
        usesModrm    = 1'b1;
      end
      8'h0C, 8'h0D: begin
        ctrl.handled = 1'b1;
        ctrl.dest    = DEST_ACC;
        ctrl.src     = SRC_IMM;
        ctrl.width   = opcode[0] ? fullWidth : W_BYTE;
        ctrl.immByte = ~opcode[0];
      end
      8'h80, 8'h81, 8'h83: begin
        if (groupOk) begin
          ctrl.handled = 1'b1;
          ctrl.dest    = DEST_RM;
          ctrl.src     = SRC_IMM;
          ctrl.width   = (opcode == 8'h80) ? W_BYTE : fullWidth;
          ctrl.immByte = (opcode != 8'h81);
          ctrl.immSext = (opcode == 8'h83);
          usesModrm    = 1'b1;
        end
      end
      default: ctrl = '0;
    endcase
  end

  assign memOperand = ctrl.handled & usesModrm & (modrm[7:6] != MOD_REGISTER);
endmodule

// File: rtl/orx_datapath.sv
module orx_datapath
  import orx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  ctrl_t             ctrl,
  input  logic [DATA_W-1:0] immIn,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] regIn,
  input  logic [DATA_W-1:0] rmIn,
  output logic [DATA_W-1:0] result,
  output logic              flagCf,
  output logic              flagPf,
  output logic              flagAf,
  output logic              flagZf,
  output logic              flagSf,
  output logic              flagOf
);
  localparam int BYTE_W = 8;
  localparam int HALF_W = DATA_W / 2;
  localparam logic [DATA_W-1:0] MASK_BYTE = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
  localparam logic [DATA_W-1:0] MASK_HALF = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
  localparam logic [DATA_W-1:0] MASK_FULL = {DATA_W{1'b1}};

  logic [DATA_W-1:0] dstOp, srcOp, immExt, widthMask, orRaw, merged;
  logic              topBit;

  always_comb begin
    if (ctrl.immSext)
      immExt = {{(DATA_W-BYTE_W){immIn[BYTE_W-1]}}, immIn[BYTE_W-1:0]};
    else if (ctrl.immByte)
      immExt = {{(DATA_W-BYTE_W){1'b0}}, immIn[BYTE_W-1:0]};
    else
      immExt = immIn;
  end

  always_comb begin
    case (ctrl.dest)
      DEST_ACC: dstOp = accIn;
      DEST_REG: dstOp = regIn;
      DEST_RM:  dstOp = rmIn;
      default:  dstOp = '0;
    endcase
    case (ctrl.src)
      SRC_REG: srcOp = regIn;
      SRC_RM:  srcOp = rmIn;
      default: srcOp = immExt;
    endcase
  end

  always_comb begin
    case (ctrl.width)
      W_BYTE:  begin widthMask = MASK_BYTE; topBit = orRaw[BYTE_W-1]; end
      W_WORD:  begin widthMask = MASK_HALF; topBit = orRaw[HALF_W-1]; end
      default: begin widthMask = MASK_FULL; topBit = orRaw[DATA_W-1]; end
    endcase
  end

  assign orRaw  = dstOp | srcOp;
  assign merged = (orRaw & widthMask) | (dstOp & ~widthMask);

  assign result = ctrl.handled ? merged : '0;
  assign flagCf = 1'b0;
  assign flagOf = 1'b0;
  assign flagAf = 1'b0;
  assign flagSf = ctrl.handled & topBit;
  assign flagZf = ctrl.handled & ((orRaw & widthMask) == '0);
  assign flagPf = ctrl.handled & ~(^orRaw[BYTE_W-1:0]);
endmodule

// File: rtl/orx_unit.sv
module orx_unit
  import orx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [7:0]        opcode,
  input  logic [7:0]        modrm,
  input  logic [DATA_W-1:0] immIn,
  input  logic              opSize32,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] regIn,
  input  logic [DATA_W-1:0] rmIn,
  output logic [DATA_W-1:0] result,
  output logic [1:0]        destSel,
  output logic              flagCf,
  output logic              flagPf,
  output logic              flagAf,
  output logic              flagZf,
  output logic              flagSf,
  output logic              flagOf,
  output logic              memOperand,
  output logic              notHandled
);
  ctrl_t ctrl;

  orx_decode decode_i (
    .opcode     (opcode),
    .modrm      (modrm),
    .opSize32   (opSize32),
    .ctrl       (ctrl),
    .memOperand (memOperand)
  );

  orx_datapath #(.DATA_W(DATA_W)) datapath_i (
    .ctrl   (ctrl),
    .immIn  (immIn),
    .accIn  (accIn),
    .regIn  (regIn),
    .rmIn   (rmIn),
    .result (result),
    .flagCf (flagCf),
    .flagPf (flagPf),
    .flagAf (flagAf),
    .flagZf (flagZf),
    .flagSf (flagSf),
    .flagOf (flagOf)
  );

  assign destSel    = ctrl.dest;
  assign notHandled = ~ctrl.handled;
endmodule

// File: rtl/orx_unit_chk.sv
module orx_unit_chk #(
  parameter int DATA_W = 32
) (
  input logic [7:0]        opcode,
  input logic [7:0]        modrm,
  input logic [DATA_W-1:0] accIn,
  input logic [DATA_W-1:0] regIn,
  input logic [DATA_W-1:0] rmIn,
  input logic [DATA_W-1:0] result,
  input logic [1:0]        destSel,
  input logic              flagCf,
  input logic              flagPf,
  input logic              flagAf,
  input logic              flagZf,
  input logic              flagSf,
  input logic              flagOf,
  input logic              memOperand,
  input logic              notHandled
);
  logic              byteForm;
  logic [DATA_W-1:0] dstSeen;

  assign byteForm = (opcode == 8'h08) || (opcode == 8'h0A) ||
                    (opcode == 8'h0C) || (opcode == 8'h80);

  always_comb begin
    case (destSel)
      2'd1:    dstSeen = accIn;
      2'd2:    dstSeen = regIn;
      2'd3:    dstSeen = rmIn;
      default: dstSeen = '0;
    endcase
  end

  always_comb begin
    // R1
    a_r1_idle_when_unhandled: assert (!notHandled ||
      (destSel == 2'd0 && result == '0 && !memOperand && !flagZf && !flagSf && !flagPf));
    // R4
    a_r4_dest_when_handled: assert (notHandled || destSel != 2'd0);
    // R8
    a_r8_flags_cleared: assert (!flagCf && !flagOf && !flagAf);
    // R7
    a_r7_upper_passthrough: assert (notHandled || !byteForm ||
      result[DATA_W-1:8] == dstSeen[DATA_W-1:8]);
    // R6
    a_r6_or_covers_dest: assert (notHandled || ((dstSeen & ~result) == '0));
    // R10
    a_r10_parity_low_byte: assert (notHandled || flagPf == ~(^result[7:0]));
    // R11
    a_r11_mem_only_modrm: assert (!memOperand ||
      (!notHandled && modrm[7:6] != 2'd3 && opcode != 8'h0C && opcode != 8'h0D));
    // R9
    a_r9_sign_zero_exclusive: assert (!(flagSf && flagZf));
  end
endmodule

bind orx_unit orx_unit_chk #(.DATA_W(DATA_W)) chk_i (
  .opcode     (opcode),
  .modrm      (modrm),
  .accIn      (accIn),
  .regIn      (regIn),
  .rmIn       (rmIn),
  .result     (result),
  .destSel    (destSel),
  .flagCf     (flagCf),
  .flagPf     (flagPf),
  .flagAf     (flagAf),
  .flagZf     (flagZf),
  .flagSf     (flagSf),
  .flagOf     (flagOf),
  .memOperand (memOperand),
  .notHandled (notHandled)
);

// File: tb/orx_unit_tb_top.sv
`timescale 1ns/1ps
module orx_unit_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0]  opcode = 8'h00, modrm = 8'h00;
  logic [31:0] immIn = '0, accIn = '0, regIn = '0, rmIn = '0;
  logic        opSize32 = 1'b0;
  logic [31:0] result;
  logic [1:0]  destSel;
  logic flagCf, flagPf, flagAf, flagZf, flagSf, flagOf, memOperand, notHandled;

  int  nTests = 0, nFail = 0;
  bit  done = 1'b0;

  orx_unit dut_i (
    .opcode(opcode), .modrm(modrm), .immIn(immIn), .opSize32(opSize32),
    .accIn(accIn), .regIn(regIn), .rmIn(rmIn), .result(result), .destSel(destSel),
    .flagCf(flagCf), .flagPf(flagPf), .flagAf(flagAf), .flagZf(flagZf),
    .flagSf(flagSf), .flagOf(flagOf), .memOperand(memOperand), .notHandled(notHandled)
  );

  // Behavioural reference, written from the requirements
  logic [31:0] eRes;
  logic [1:0]  eDest;
  logic eNh, eSf, eZf, ePf, eMem;

  task automatic model();
    int w = 0;
    logic [31:0] d = 0, s = 0, m;
    bit ok = 1'b1, hasModrm = 1'b1;
    case (opcode)
      8'h08: begin w = 8;  d = rmIn;  s = regIn; eDest = 3; end
      8'h09: begin w = opSize32 ? 32 : 16; d = rmIn; s = regIn; eDest = 3; end
      8'h0A: begin w = 8;  d = regIn; s = rmIn;  eDest = 2; end
      8'h0B: begin w = opSize32 ? 32 : 16; d = regIn; s = rmIn; eDest = 2; end
      8'h0C: begin w = 8;  d = accIn; s = {24'h0, immIn[7:0]}; eDest = 1; hasModrm = 0; end
      8'h0D: begin w = opSize32 ? 32 : 16; d = accIn; s = immIn; eDest = 1; hasModrm = 0; end
      8'h80: begin w = 8;  d = rmIn;  s = {24'h0, immIn[7:0]}; eDest = 3; ok = (modrm[5:3] == 1); end
      8'h81: begin w = opSize32 ? 32 : 16; d = rmIn; s = immIn; eDest = 3; ok = (modrm[5:3] == 1); end
      8'h83: begin w = opSize32 ? 32 : 16; d = rmIn; s = {{24{immIn[7]}}, immIn[7:0]};
                   eDest = 3; ok = (modrm[5:3] == 1); end
      default: ok = 1'b0;
    endcase
    if (!ok) begin
      eNh = 1; eRes = 0; eDest = 0; eSf = 0; eZf = 0; ePf = 0; eMem = 0;
    end else begin
      m    = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
      eNh  = 0;
      eRes = ((d | s) & m) | (d & ~m);
      eSf  = eRes[w-1];
      eZf  = ((eRes & m) == 0);
      ePf  = ($countones(eRes[7:0]) % 2) == 0;
      eMem = hasModrm && (modrm[7:6] != 2'd3);
    end
  endtask

  task automatic chk(input bit good, input string what, input logic [31:0] act, exp);
    nTests++;
    if (!good) begin
      nFail++;
      $display("FAIL %s op=%h modrm=%h actual=%h expected=%h", what, opcode, modrm, act, exp);
    end
  endtask

  task automatic compare();
    model();
    chk(notHandled == eNh, "R1/R2 notHandled", 32'(notHandled), 32'(eNh));
    chk(destSel == eDest, "R4 destSel", 32'(destSel), 32'(eDest));
    chk(result == eRes, "R3/R5/R6/R7 result", result, eRes);
    chk(!flagCf && !flagOf, "R8 cf/of", {30'h0, flagCf, flagOf}, 32'h0);
    chk(flagSf == eSf && flagZf == eZf, "R9 sf/zf", {30'h0, flagSf, flagZf}, {30'h0, eSf, eZf});
    chk(flagPf == ePf, "R10 pf", 32'(flagPf), 32'(ePf));
    chk(memOperand == eMem, "R11 memOperand", 32'(memOperand), 32'(eMem));
  endtask

  task automatic apply(input logic [7:0] op, md, input logic [31:0] im, ac, rg, rm, input bit s32);
    @(posedge clk);
    opcode = op; modrm = md; immIn = im; accIn = ac; regIn = rg; rmIn = rm; opSize32 = s32;
    @(negedge clk);
    compare();
  endtask

  initial begin
    #20000;
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  localparam logic [7:0] OPS [12] = '{8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C, 8'h0D,
                                      8'h80, 8'h81, 8'h83, 8'h82, 8'h00, 8'h0F};

  initial begin
    // Initial state: opcode 0x00 is not an OR form (R1)
    @(negedge clk);
    compare();
    // R3, R7: byte form keeps upper bits of r/m
    apply(8'h08, 8'hC0, 0, 0, 32'h0000_0081, 32'hABCD_EF00, 1'b1);
    // R3: 16-bit vs 32-bit register form
    apply(8'h0B, 8'hC8, 0, 0, 32'h1234_0000, 32'h0000_8000, 1'b0);
    apply(8'h0B, 8'hC8, 0, 0, 32'h1234_0000, 32'h8000_0000, 1'b1);
    // R9: zero result at each width
    apply(8'h0A, 8'hC0, 0, 0, 32'hFFFF_FF00, 32'h0000_0000, 1'b1);
    apply(8'h09, 8'hC0, 0, 0, 32'h0, 32'hFFFF_0000, 1'b0);
    apply(8'h09, 8'hC0, 0, 0, 32'h0, 32'h0, 1'b1);
    // R5: sign extension of 0x83 at 16 and 32 bits, top bit set and clear
    apply(8'h83, 8'h08, 32'h0000_0080, 0, 0, 32'h5555_0001, 1'b0);
    apply(8'h83, 8'hC8, 32'h0000_0080, 0, 0, 32'h0000_0001, 1'b1);
    apply(8'h83, 8'hC8, 32'hFFFF_FF7F, 0, 0, 32'h0000_0000, 1'b1);
    // R5: 0x81 full immediate, 0x80 byte only
    apply(8'h81, 8'h48, 32'hDEAD_BEEF, 0, 0, 32'h0, 1'b0);
    apply(8'h80, 8'hC8, 32'hFFFF_FF01, 0, 0, 32'h1111_1100, 1'b1);
    // R4: accumulator forms
    apply(8'h0C, 8'h00, 32'h0000_0003, 32'h7700_0010, 0, 0, 1'b1);
    apply(8'h0D, 8'h00, 32'h8000_0000, 32'h0000_0001, 0, 0, 1'b1);
    // R2: group opcodes with a reg field other than 1
    apply(8'h80, 8'hC0, 32'hFF, 0, 0, 32'h1, 1'b1);
    apply(8'h81, 8'hF8, 32'hFF, 0, 0, 32'h1, 1'b1);
    apply(8'h83, 8'h10, 32'hFF, 0, 0, 32'h1, 1'b0);
    // R11: memory mod classes
    apply(8'h0B, 8'h88, 0, 0, 32'h1, 32'h2, 1'b1);
    apply(8'h0D, 8'h00, 32'h1, 32'h2, 0, 0, 1'b0);
    // Random mix
    for (int i = 0; i < 1500; i++) begin
      logic [7:0] md;
      md = 8'($urandom);
      if (i % 2 == 0) md[5:3] = 3'd1;
      apply(OPS[$urandom % 12], md, $urandom, $urandom, $urandom,
            (i % 5 == 0) ? 32'h0 : $urandom, 1'($urandom));
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule